// File: doc/BRIEF.md
# Bounded Interrupt-Disable Monitor

This block sits next to the interrupt controller of a small CPU and keeps untrusted code from holding interrupts off for an unbounded time. Untrusted code cannot use the ordinary global interrupt disable. It issues a timed-disable request that carries a cycle count instead. The block then masks interrupts for exactly that many cycles and unmasks them again without any further instruction.

Trusted code sets a cap register at start-up. An untrusted request longer than the cap is refused and raises a one-cycle security panic. An untrusted plain disable also raises the panic. Trusted code is exempt from the cap.

A request can arrive while an interrupt is already pending. In that case the interrupt goes first. The request is parked in a one-entry hold slot and the CPU is told to stall through the replay output. The parked window starts by itself once the pending interrupts have been serviced.

Top module: `atomic_window_guard`

## Requirements
- R1: An accepted timed-disable request with count Y (Y nonzero, no interrupt pending) drives `irq_en` low in the Y cycles after the clock edge that takes the request. `irq_en` then returns high by itself.
- R2: The cap register resets to `CAP_RST` (16 by default). A `cap_we` pulse updates it only when `trusted` is high. An untrusted write leaves the old cap in force.
- R3: A plain-disable strobe while `trusted` is low raises `panic` for one cycle after the edge. The same strobe with `trusted` high raises no panic.
- R4: A timed-disable request that arrives while a window is counting, or while a request is parked, is ignored. It neither lengthens the window nor replaces the parked count.
- R5: A request that arrives while any bit of `irq_pend` is set is parked, and `replay` goes high after that edge. On the first edge at which `irq_pend` is all zero, the parked window starts with its stored count and `replay` falls.
- R6: An untrusted request whose count is greater than the cap raises `panic` and leaves `irq_en` high. A count equal to the cap is accepted.
- R7: With `trusted` high, a request longer than the cap is accepted and raises no panic.
- R8: A request with count zero has no effect on any output.
- R9: Every panic clears the running window and any parked request, so `irq_en` is high and `replay` is low in the cycle that `panic` is high. A panic cannot be masked.
- R10: After reset, `irq_en` is high and both `panic` and `replay` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tdis_req | input | 1 | Decoded timed-disable strobe |
| tdis_cycles | input | CNT_W | Cycle count of the timed disable |
| gdis_req | input | 1 | Decoded plain (untimed) disable strobe |
| trusted | input | 1 | CPU is in trusted mode |
| irq_pend | input | IRQ_W | Pending interrupt lines |
| cap_we | input | 1 | Write strobe for the cap register |
| cap_wdata | input | CNT_W | New cap value |
| irq_en | output | 1 | Effective interrupt enable |
| panic | output | 1 | One-cycle security panic |
| replay | output | 1 | A request is parked; CPU stalls and replays |

## Verification
Several properties are checked by assertions on every cycle:
- a running window counts down by exactly one per cycle;
- a parked count never changes while it waits;
- the parked window starts with the stored count once pending interrupts clear;
- an untrusted plain disable is always followed by a panic;
- a panic always coincides with interrupts enabled and nothing parked;
- an untrusted cap write never moves the cap.

Other behaviour can only be shown by the bench's scenarios. These are the exact window length seen at the enable pin, the acceptance of a count equal to the cap versus panic one above it, the trusted exemption, the zero-count no-op, and the effect of a changed cap on later requests. A random mix of overlapping requests, pending-interrupt stretches and cap writes exposes the interplay between nesting, deferral and panic.

// File: rtl/awg_pkg.sv
`timescale 1ns/1ps
package awg_pkg;

  typedef struct packed {
    logic start;   // open a window now
    logic defer;   // park the request behind a pending interrupt
    logic viol;    // security violation this cycle
  } awg_decision_t;

  // Untrusted count above the cap is a violation; trusted code is exempt.
  function automatic logic exceeds_cap(input logic [31:0] y,
                                       input logic [31:0] cap,
                                       input logic        priv);
    return !priv && (y > cap);
  endfunction

  // One step of a window counter that saturates at zero.
  function automatic logic [31:0] tick_down(input logic [31:0] c);
    return (c == 32'd0) ? 32'd0 : c - 32'd1;
  endfunction

endpackage

// File: rtl/awg_cap_reg.sv
`timescale 1ns/1ps
module awg_cap_reg #(
  parameter int CNT_W   = 8,
  parameter int CAP_RST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             trusted,
  output logic [CNT_W-1:0] cap
);
  logic wr_ok;
  assign wr_ok = we && trusted;

  always_ff @(posedge clk) begin
    if (!rst_n)     cap <= CNT_W'(CAP_RST);
    else if (wr_ok) cap <= wdata;
  end

  // R2: untrusted code cannot move the cap
  a_r2_cap_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !trusted) |=> $stable(cap));
endmodule

// File: rtl/awg_policy.sv
`timescale 1ns/1ps
module awg_policy
  import awg_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int IRQ_W = 4
) (
  input  logic             tdis_req,
  input  logic [CNT_W-1:0] tdis_cycles,
  input  logic             gdis_req,
  input  logic             trusted,
  input  logic [IRQ_W-1:0] irq_pend,
  input  logic [CNT_W-1:0] cap,
  input  logic             busy,
  input  logic             held,
  output awg_decision_t    dec
);
  logic slot_free, real_req, plain_bad, long_bad, any_pend;

  assign slot_free = !busy && !held;                      // R4 nesting filter
  assign real_req  = tdis_req && slot_free && (tdis_cycles != '0); // R8
  assign plain_bad = gdis_req && !trusted;                // R3
  assign long_bad  = real_req &&
                     exceeds_cap(32'(tdis_cycles), 32'(cap), trusted); // R6, R7
  assign any_pend  = |irq_pend;

  always_comb begin
    dec.viol  = plain_bad || long_bad;
    dec.start = real_req && !dec.viol && !any_pend;
    dec.defer = real_req && !dec.viol &&  any_pend;       // R5
  end
endmodule

// File: rtl/awg_window.sv
`timescale 1ns/1ps
module awg_window
  import awg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  awg_decision_t    dec,
  input  logic [CNT_W-1:0] y,
  input  logic             pend_any,
  output logic             busy,
  output logic             held
);
  logic [CNT_W-1:0] cnt_q, held_y_q;
  logic             held_q, replay_go;

  assign replay_go = held_q && !pend_any && (cnt_q == '0);
  assign busy      = (cnt_q != '0);
  assign held      = held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      held_q   <= 1'b0;
      held_y_q <= '0;
    end else if (dec.viol) begin          // R9: panic wipes everything
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else begin
      if (dec.start)      cnt_q <= y;
      else if (replay_go) cnt_q <= held_y_q;
      else                cnt_q <= CNT_W'(tick_down(32'(cnt_q)));
      if (dec.defer) begin
        held_q   <= 1'b1;
        held_y_q <= y;
      end else if (replay_go) begin
        held_q <= 1'b0;
      end
    end
  end

  // R1: a running window loses exactly one per cycle
  a_r1_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !dec.viol) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R4: a parked count is never overwritten
  a_r4_held_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !dec.viol) |=> $stable(held_y_q));

  // R5: the parked window opens with its stored count
  a_r5_replay_start: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_go && !dec.viol) |=> (cnt_q == $past(held_y_q) && !held_q));
endmodule

// File: rtl/atomic_window_guard.sv
`timescale 1ns/1ps
module atomic_window_guard
  import awg_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int IRQ_W   = 4,
  parameter int CAP_RST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tdis_req,
  input  logic [CNT_W-1:0] tdis_cycles,
  input  logic             gdis_req,
  input  logic             trusted,
  input  logic [IRQ_W-1:0] irq_pend,
  input  logic             cap_we,
  input  logic [CNT_W-1:0] cap_wdata,
  output logic             irq_en,
  output logic             panic,
  output logic             replay
);
  logic [CNT_W-1:0] cap;
  logic             busy, held, pend_any;
  awg_decision_t    dec;

  assign pend_any = |irq_pend;

  awg_cap_reg #(.CNT_W(CNT_W), .CAP_RST(CAP_RST)) u_cap (
    .clk(clk), .rst_n(rst_n), .we(cap_we), .wdata(cap_wdata),
    .trusted(trusted), .cap(cap));

  awg_policy #(.CNT_W(CNT_W), .IRQ_W(IRQ_W)) u_pol (
    .tdis_req(tdis_req), .tdis_cycles(tdis_cycles), .gdis_req(gdis_req),
    .trusted(trusted), .irq_pend(irq_pend), .cap(cap), .busy(busy),
    .held(held), .dec(dec));

  awg_window #(.CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .dec(dec), .y(tdis_cycles),
    .pend_any(pend_any), .busy(busy), .held(held));

  always_ff @(posedge clk) begin
    if (!rst_n) panic <= 1'b0;
    else        panic <= dec.viol;
  end

  assign irq_en = !busy;
  assign replay = held;

  // R3: an untrusted plain disable always panics
  a_r3_plain_panics: assert property (@(posedge clk) disable iff (!rst_n)
    (gdis_req && !trusted) |=> panic);

  // R9: panic leaves interrupts open and nothing parked
  a_r9_panic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    panic |-> (irq_en && !replay));

  // R7: trusted requests never panic on length
  a_r7_trusted_exempt: assert property (@(posedge clk) disable iff (!rst_n)
    (trusted && !gdis_req) |=> !panic);
endmodule

// File: tb/atomic_window_guard_test.sv
`timescale 1ns/1ps
module atomic_window_guard_test;
  localparam int CW = 8;
  localparam int IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic td = 0, gd = 0, tr = 0, we = 0;
  logic [CW-1:0] ty = '0, wd = '0;
  logic [IW-1:0] pend = '0;
  logic irq_en, panic, replay;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // reference state
  int  m_left = 0, m_cap = 16, m_hy = 0;
  bit  m_hold = 0, m_pan = 0;

  atomic_window_guard #(.CNT_W(CW), .IRQ_W(IW), .CAP_RST(16)) uut (
    .clk(clk), .rst_n(rst_n), .tdis_req(td), .tdis_cycles(ty),
    .gdis_req(gd), .trusted(tr), .irq_pend(pend), .cap_we(we),
    .cap_wdata(wd), .irq_en(irq_en), .panic(panic), .replay(replay));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic bit is_bad(bit g, bit t, bit q, int y, bit free, int cap);
    if (g && !t) return 1;
    return q && free && y != 0 && !t && y > cap;
  endfunction

  task automatic model_step();
    bit free = (m_left == 0) && !m_hold;
    bit req  = td && free && (ty != 0);
    bit bad  = is_bad(gd, tr, td, int'(ty), free, m_cap);
    m_pan = bad;
    if (bad) begin m_left = 0; m_hold = 0; end
    else if (req && pend == 0) m_left = ty;
    else if (req) begin m_hold = 1; m_hy = ty; end
    else if (m_hold && pend == 0 && m_left == 0) begin m_left = m_hy; m_hold = 0; end
    else if (m_left > 0) m_left--;
    if (we && tr) m_cap = wd;
  endtask

  task automatic chk(string tag, bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, irq_en, m_left == 0, "irq_en");
    chk(tag, panic,  m_pan,       "panic");
    chk(tag, replay, m_hold,      "replay");
    td = 0; gd = 0; we = 0;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10", irq_en, 1, "irq_en"); chk("R10", panic, 0, "panic");
    chk("R10", replay, 0, "replay");
    rst_n = 1;

    // R1 window of 5 cycles
    td = 1; ty = 5; step("R1");
    chk("R1", irq_en, 0, "irq_en_direct");
    idle("R1", 4);
    chk("R1", irq_en, 0, "irq_en_last");
    step("R1");
    chk("R1", irq_en, 1, "irq_en_reopen");

    // R4 nested request ignored
    td = 1; ty = 6; step("R4");
    idle("R4", 2);
    td = 1; ty = 30; step("R4");
    idle("R4", 2);
    step("R4");
    chk("R4", irq_en, 1, "not_stretched");

    // R8 zero count
    td = 1; ty = 0; step("R8");
    chk("R8", irq_en, 1, "zero_noop");

    // R6 over cap panics, equal to cap accepted
    td = 1; ty = 17; step("R6");
    chk("R6", panic, 1, "over_cap"); chk("R6", irq_en, 1, "over_cap_open");
    td = 1; ty = 16; step("R6");
    chk("R6", irq_en, 0, "at_cap"); idle("R6", 16);

    // R7 trusted exempt
    tr = 1; td = 1; ty = 100; step("R7");
    chk("R7", panic, 0, "no_panic"); idle("R7", 100); tr = 0;

    // R2 untrusted write ignored, trusted write used
    we = 1; wd = 3; step("R2");
    td = 1; ty = 16; step("R2");
    chk("R2", irq_en, 0, "old_cap_used"); idle("R2", 16);
    tr = 1; we = 1; wd = 4; step("R2"); tr = 0;
    td = 1; ty = 5; step("R2");
    chk("R2", panic, 1, "new_cap_used");

    // R3 plain disable
    gd = 1; step("R3"); chk("R3", panic, 1, "untrusted");
    tr = 1; gd = 1; step("R3"); chk("R3", panic, 0, "trusted"); tr = 0;

    // R5 deferral and replay, R4 during park
    pend = 4'b0010; td = 1; ty = 3; step("R5");
    chk("R5", replay, 1, "parked"); chk("R5", irq_en, 1, "irq_first");
    td = 1; ty = 2; step("R4");
    idle("R5", 2);
    pend = 0; step("R5");
    chk("R5", replay, 0, "released"); chk("R5", irq_en, 0, "window_on");
    idle("R5", 3);
    chk("R5", irq_en, 1, "window_len");

    // R9 panic clears window
    td = 1; ty = 4; step("R9");
    gd = 1; step("R9");
    chk("R9", irq_en, 1, "cleared"); chk("R9", panic, 1, "panic");
    pend = 1; td = 1; ty = 2; step("R9");
    gd = 1; step("R9"); chk("R9", replay, 0, "park_cleared");
    pend = 0; idle("R9", 2);

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      td = ($urandom % 6) == 0;
      ty = CW'($urandom % 24);
      gd = ($urandom % 50) == 0;
      tr = ($urandom % 5) == 0;
      we = ($urandom % 40) == 0;
      wd = CW'(4 + $urandom % 20);
      if (($urandom % 8) == 0) pend = (($urandom % 3) == 0) ? IW'($urandom) : '0;
      step("R1");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule